// File: doc/BRIEF.md
# Timer with Dual-Edge Input Capture

This block is one general-purpose timer channel behind a small word-addressed register bank. A 16-bit up-counter advances on ticks from a power-of-two prescaler. When the count meets the compare value on a tick, the counter returns to zero and a match event fires. In auto-reload mode the counter keeps running after the match. In single-shot mode it stops by clearing its own enable bit.

An external capture pin passes through a two-flop synchronizer, and its edges are then detected. A two-bit capture mode decides which edges latch the current count. Rising edges go to one capture register and falling edges go to another. Every event also sets a sticky status flag, which software clears by writing 1. Each flag has its own enable, and the enabled flags are ORed onto a single interrupt line.

Software sets the prescaler, mode and compare value, then sets the enable bit. It either polls the status word or waits for the interrupt.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the control word, status, count, both capture registers and irq are 0, and compare reads 0xFFFF.
- R2: Byte offsets are 0x80 control, 0x84 status, 0x88 compare, 0x8C count, 0x90 rising capture and 0x94 falling capture. Any other address reads 0, and a write to it changes nothing.
- R3: Control bits [3:0] hold a prescaler code n. After the enable write, the count advances once every 2^n clock cycles. The first advance comes 2^n cycles after the write. Codes 9 to 15 behave as code 8 (divide by 256).
- R4: The count advances only while control bit 5 (enable) is set, and it holds its value while that bit is clear.
- R5: With control bit 4 clear (auto-reload), a tick at count == compare sets the count to 0 and the counter keeps running. A compare value of 0xFFFF gives a full-range free-running count that wraps to 0.
- R6: With control bit 4 set (single-shot), a tick at count == compare sets the count to 0 and clears control bit 5 by itself.
- R7: A match event sets status bit 0.
- R8: The capture mode is control bits [7:6]: 00 none, 01 rising only, 10 falling only, 11 both. A rising edge of cap_in that the mode selects copies the count to the rising capture register and sets status bit 2. A selected falling edge copies the count to the falling capture register and sets status bit 1. An edge the mode does not select changes nothing.
- R9: Status bits stay set until software writes 1 to that bit. Writing 0 to a status bit leaves it unchanged. If an event and a clear hit the same bit in one cycle, the event wins.
- R10: irq is 1 exactly when some status bit is set and its enable is set. The enables are control bit 8 for match, bit 9 for falling capture and bit 10 for rising capture.
- R11: The count register is read-only, and a write to it is ignored.
- R12: A write to control with bit 5 clear resets the prescaler phase. The next enable then starts a full 2^n-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that ends its bus cycle. Read data is valid in the same cycle as the address, so the bench drives on falling edges and samples 1 ns later. After the enable write, the count after k edges is floor(k / 2^n), folded by the compare and mode rules. The bench evaluates this formula at the exact edge count of each read, and it recomputes the edge count for the status and control reads that follow. A capture lands three edges after the pin changes: two synchronizer stages and the edge register. The bench therefore waits four edges, with the count frozen, before it reads a capture register.

// File: rtl/ectmr_pkg.sv
`timescale 1ns/1ps
package ectmr_pkg;
  localparam int REG_W     = 32;
  localparam int MAX_SHIFT = 8;
  localparam int DIV_W     = MAX_SHIFT;

  localparam logic [7:0] OFS_CTRL  = 8'h80;
  localparam logic [7:0] OFS_STAT  = 8'h84;
  localparam logic [7:0] OFS_CMP   = 8'h88;
  localparam logic [7:0] OFS_CNT   = 8'h8C;
  localparam logic [7:0] OFS_CAPR  = 8'h90;
  localparam logic [7:0] OFS_CAPF  = 8'h94;

  // control word, MSB first: bit10 down to bit0
  typedef struct packed {
    logic       ie_rise;
    logic       ie_fall;
    logic       ie_match;
    logic [1:0] cap_mode;
    logic       enable;
    logic       one_shot;
    logic [3:0] psc;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = 3;

  // prescaler shift, clamped to the largest supported division
  function automatic int unsigned psc_shift(input logic [3:0] code);
    return (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
  endfunction

  // low-bit mask whose all-ones pattern marks the last cycle of a period
  function automatic logic [DIV_W-1:0] psc_mask(input logic [3:0] code);
    int unsigned s;
    s = psc_shift(code);
    return DIV_W'((1 << s) - 1);
  endfunction

  // auto-reload / single-shot next value on a tick
  function automatic logic [15:0] next_count(input logic [15:0] cur,
                                             input logic [15:0] cmp);
    return (cur == cmp) ? 16'd0 : cur + 16'd1;
  endfunction
endpackage

// File: rtl/ectmr_prescaler.sv
`timescale 1ns/1ps
module ectmr_prescaler
  import ectmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       phase_clr,
  input  logic [3:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = psc_mask(code);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)         div_q <= '0;
    else if (phase_clr) div_q <= '0;
    else if (run)       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ectmr_counter.sv
`timescale 1ns/1ps
module ectmr_counter
  import ectmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             match_evt
);
  assign match_evt = tick && (count == cmp);

  generate
    if (CNT_W == 16) begin : g_fn
      always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= next_count(count, cmp);
      end
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (match_evt) count <= '0;
        else if (tick)      count <= count + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ectmr_capture.sv
`timescale 1ns/1ps
module ectmr_capture #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] count,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic [CNT_W-1:0] cap_rise,
  output logic [CNT_W-1:0] cap_fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      last_q <= pin_s;
    end
  end

  assign rise_evt = mode[0] &&  pin_s && !last_q;
  assign fall_evt = mode[1] && !pin_s &&  last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_rise <= '0;
      cap_fall <= '0;
    end else begin
      if (rise_evt) cap_rise <= count;
      if (fall_evt) cap_fall <= count;
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
  import ectmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic              irq
);
  localparam int CNT_PAD  = REG_W - CNT_W;
  localparam int CTRL_PAD = REG_W - CTRL_W;
  localparam int STAT_PAD = REG_W - STAT_W;

  ctrl_t              ctrl_q;
  logic [STAT_W-1:0]  status_q;
  logic [CNT_W-1:0]   cmp_q;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   cap_rise;
  logic [CNT_W-1:0]   cap_fall;

  logic               wr_hit;
  logic               ctrl_wr;
  logic               stat_wr;
  logic               cmp_wr;
  logic               phase_clr;
  logic               tick;
  logic               run;
  logic               match_evt;
  logic               rise_evt;
  logic               fall_evt;
  logic               ctrl_oneshot;
  logic [STAT_W-1:0]  stat_clr;
  logic [STAT_W-1:0]  stat_set;
  logic [STAT_W-1:0]  ie_vec;

  assign wr_hit    = bus_sel && bus_wr;
  assign ctrl_wr   = wr_hit && (bus_addr == ADDR_W'(OFS_CTRL));
  assign stat_wr   = wr_hit && (bus_addr == ADDR_W'(OFS_STAT));
  assign cmp_wr    = wr_hit && (bus_addr == ADDR_W'(OFS_CMP));
  assign phase_clr = ctrl_wr && !bus_wdata[5];

  assign run          = ctrl_q.enable;
  assign ctrl_oneshot = ctrl_q.one_shot;
  assign stat_clr     = stat_wr ? bus_wdata[STAT_W-1:0] : '0;
  assign stat_set     = {rise_evt, fall_evt, match_evt};
  assign ie_vec       = {ctrl_q.ie_rise, ctrl_q.ie_fall, ctrl_q.ie_match};

  ectmr_prescaler u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .phase_clr (phase_clr),
    .code      (ctrl_q.psc),
    .tick      (tick)
  );

  ectmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmp       (cmp_q),
    .count     (count),
    .match_evt (match_evt)
  );

  ectmr_capture #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .mode     (ctrl_q.cap_mode),
    .count    (count),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall)
  );

  // control: software write wins over the single-shot self-clear
  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (ctrl_wr)                  ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    else if (match_evt && ctrl_oneshot) ctrl_q.enable <= 1'b0;
  end

  // sticky flags, a new event beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_wr) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CTRL): bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      ADDR_W'(OFS_STAT): bus_rdata = {{STAT_PAD{1'b0}}, status_q};
      ADDR_W'(OFS_CMP):  bus_rdata = {{CNT_PAD{1'b0}}, cmp_q};
      ADDR_W'(OFS_CNT):  bus_rdata = {{CNT_PAD{1'b0}}, count};
      ADDR_W'(OFS_CAPR): bus_rdata = {{CNT_PAD{1'b0}}, cap_rise};
      ADDR_W'(OFS_CAPF): bus_rdata = {{CNT_PAD{1'b0}}, cap_fall};
      default:           bus_rdata = '0;
    endcase
  end

  assign irq = |(status_q & ie_vec);
endmodule

// File: rtl/ectmr_checker.sv
`timescale 1ns/1ps
module ectmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic [CNT_W-1:0] count,
  input logic             match_evt,
  input logic             one_shot,
  input logic             ctrl_wr,
  input logic [2:0]       status,
  input logic [2:0]       stat_clr,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic [CNT_W-1:0] cap_rise,
  input logic [CNT_W-1:0] cap_fall,
  input logic [2:0]       ie_vec,
  input logic             irq
);
  assert_tick_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_reload_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> (count == '0));

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && one_shot && !ctrl_wr) |=> !run);

  assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> status[0]);

  assert_rise_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(cap_rise));

  assert_fall_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(cap_fall));

  assert_sticky_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !stat_clr[0]) |=> status[0]);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_vec == 3'b000) |-> !irq);
endmodule

bind edge_capture_timer ectmr_checker #(.CNT_W(CNT_W)) u_ectmr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .run       (run),
  .count     (count),
  .match_evt (match_evt),
  .one_shot  (ctrl_oneshot),
  .ctrl_wr   (ctrl_wr),
  .status    (status_q),
  .stat_clr  (stat_clr),
  .rise_evt  (rise_evt),
  .fall_evt  (fall_evt),
  .cap_rise  (cap_rise),
  .cap_fall  (cap_fall),
  .ie_vec    (ie_vec),
  .irq       (irq)
);

// File: tb/edge_capture_timer_bench.sv
`timescale 1ns/1ps
module edge_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_capture_timer u_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .irq(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h80, A_STAT = 8'h84, A_CMP = 8'h88,
                         A_CNT = 8'h8C, A_CAPR = 8'h90, A_CAPF = 8'h94;

  // {code[47:44], single[43:40], compare[39:24], wait edges[23:0]}
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {4'd0,  4'd0, 16'hFFFF, 24'd5},
    {4'd1,  4'd0, 16'hFFFF, 24'd7},
    {4'd2,  4'd0, 16'hFFFF, 24'd9},
    {4'd3,  4'd0, 16'hFFFF, 24'd20},
    {4'd4,  4'd0, 16'hFFFF, 24'd31},
    {4'd4,  4'd0, 16'hFFFF, 24'd32},
    {4'd8,  4'd0, 16'hFFFF, 24'd600},
    {4'd13, 4'd0, 16'hFFFF, 24'd600},
    {4'd0,  4'd0, 16'd4,    24'd12},
    {4'd1,  4'd0, 16'd3,    24'd13},
    {4'd0,  4'd1, 16'd3,    24'd10},
    {4'd0,  4'd1, 16'd6,    24'd4},
    {4'd2,  4'd1, 16'd2,    24'd20},
    {4'd0,  4'd0, 16'hFFFF, 24'd65538}
  };

  function automatic longint ticks_after(input int code, input longint k);
    int s;
    s = (code > 8) ? 8 : code;
    return k >> s;
  endfunction

  function automatic longint exp_count(input int code, input bit single,
                                       input longint cmp, input longint k);
    longint t;
    t = ticks_after(code, k);
    if (single) return (t > cmp) ? 0 : t;
    return t % (cmp + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; cap_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pin_and_wait(input logic v);
    cap_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    do_reset();

    // R1 reset values
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_CMP,  d); chk("R1 compare", d, 32'h0000FFFF);
    rd(A_CNT,  d); chk("R1 count", d, 32'h0);
    rd(A_CAPR, d); chk("R1 cap rise", d, 32'h0);
    rd(A_CAPF, d); chk("R1 cap fall", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 reserved space
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d);  chk("R2 reserved read", d, 32'h0);
    rd(A_CTRL, d); chk("R2 reserved write ignored", d, 32'h0);
    rd(8'h98, d);  chk("R2 past map", d, 32'h0);

    // R11 count read-only
    wr(A_CNT, 32'h1234);
    rd(A_CNT, d); chk("R11 count write ignored", d, 32'h0);

    // vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      int code; bit single; longint cmp; longint w; longint t2;
      code = int'(VEC[i][47:44]); single = VEC[i][40];
      cmp = longint'(VEC[i][39:24]); w = longint'(VEC[i][23:0]);
      do_reset();
      wr(A_CMP, 32'(cmp));
      wr(A_CTRL, 32'h20 | (32'(single) << 4) | 32'(code));
      repeat (int'(w)) @(negedge clk);
      rd(A_CNT, d);
      chk($sformatf("R3 R5 R6 count vec%0d", i), d, 32'(exp_count(code, single, cmp, w)));
      rd(A_STAT, d);
      chk($sformatf("R7 match flag vec%0d", i), d,
          (ticks_after(code, w + 1) > cmp) ? 32'h1 : 32'h0);
      t2 = ticks_after(code, w + 2);
      rd(A_CTRL, d);
      chk($sformatf("R6 enable vec%0d", i), {31'b0, d[5]},
          (single && t2 > cmp) ? 32'h0 : 32'h1);
    end

    // R12 phase reset and R4 hold while disabled
    do_reset();
    wr(A_CTRL, 32'h22);
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'h02);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); chk("R4 held while off", d, 32'h0);
    wr(A_CTRL, 32'h22);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); chk("R12 no tick before full period", d, 32'h0);
    rd(A_CNT, d); chk("R12 tick after full period", d, 32'h1);

    // R9 R10 sticky status and interrupt mask
    do_reset();
    wr(A_CMP, 32'd2);
    wr(A_CTRL, 32'h20);
    repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R7 match set", d, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h120);
    #1 chk("R10 irq on enable", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h100);
    wr(A_STAT, 32'h6);
    rd(A_STAT, d); chk("R9 other bits leave match", d, 32'h1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R9 write zero no effect", d, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R9 write one clears", d, 32'h0);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);

    // R8 capture modes
    do_reset();
    wr(A_CTRL, 32'h20);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h00);              // count frozen at 10
    pin_and_wait(1'b1); pin_and_wait(1'b0);
    rd(A_STAT, d); chk("R8 mode none no flag", d, 32'h0);
    rd(A_CAPR, d); chk("R8 mode none no rise cap", d, 32'h0);
    rd(A_CAPF, d); chk("R8 mode none no fall cap", d, 32'h0);
    wr(A_CTRL, 32'h80);
    pin_and_wait(1'b1);
    rd(A_CAPR, d); chk("R8 fall-only ignores rise", d, 32'h0);
    pin_and_wait(1'b0);
    rd(A_CAPF, d); chk("R8 fall capture", d, 32'd10);
    rd(A_STAT, d); chk("R8 fall flag", d, 32'h2);
    wr(A_CTRL, 32'h40);
    pin_and_wait(1'b1);
    rd(A_CAPR, d); chk("R8 rise capture", d, 32'd10);
    wr(A_CTRL, 32'h20);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 32'hC0);              // count frozen at 15
    rd(A_CNT, d); chk("R4 count before both", d, 32'd15);
    pin_and_wait(1'b0);
    rd(A_CAPF, d); chk("R8 both fall", d, 32'd15);
    pin_and_wait(1'b1);
    rd(A_CAPR, d); chk("R8 both rise", d, 32'd15);
    rd(A_STAT, d); chk("R8 both flags", d, 32'h6);
    wr(A_CTRL, 32'h4C0);
    #1 chk("R10 irq from rise flag", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule